// File: doc/BRIEF.md
# Platform Sleep-State Sequencer

This block tracks a host platform through its power states (fully off, soft off, suspend-to-RAM, running, and an optional low-power idle state entered from running) and drives the side effects of each move. Every move between two resting states passes through a named transition state. That transition state lasts one clock cycle, except the bounded wait for the power rails when the platform leaves fully off.

Its inputs are the active-low sleep indicators for the S3, S4 and S0 levels, a combined core power-good, a rails-ready flag, a wake request, a host flag announcing an idle suspend, and a throttle request. The sleep indicators, power-good and rails-ready cross into the clock domain through synchroniser chains. Wake, idle-suspend and throttle requests are taken as already synchronous.

Its outputs are the current state code, a forced-shutdown strobe with a reason code, a three-level radio control, a CPU throttle pin, and single-cycle startup, resume, suspend and shutdown event pulses. In every state that holds power, losing power-good makes the sequencer fall back to the next lower state. The low-power idle state is entered only when the host has announced the suspend.

Top module: `slpseq_top`

## Requirements
- R1: While reset is held, and in the cycle after it, the outputs read as follows. `pstate` is 0 (G3), `radio_ctrl` is 0 (off), `shutdown_strobe` is 0 and `shutdown_why` is 0 (none). All four event pulses are 0. `cpu_throttle` sits at its asserted level, which is 0 when THROTTLE_ACTIVE_LOW is 1.
- R2: The `pstate` codes are G3=0, G3S5=1, S5=2, S5S3=3, S3=4, S3S0=5, S0=6, S0S3=7, S0S0IX=8, S0IX=9, S0IXS0=10, S3S5=11 and S5G3=12. A `wake_req` seen in G3 moves the sequencer to G3S5. G3S5 moves to S5 on the first edge at which the synchronised rails-ready is high.
- R3: The sequencer stays in G3S5 for at most WAIT_CYCLES cycles. If rails-ready has not arrived by then, it returns to G3 and raises `shutdown_strobe` for one cycle with `shutdown_why`=2 (wait timeout). The strobe appears in the first cycle back in G3.
- R4: In S5, a high S4 indicator moves the sequencer to S5S3. S5S3 with power-good moves to S3 and pulses `evt_startup` in the first S3 cycle. S5S3 without power-good moves to S5G3 with `shutdown_strobe` and `shutdown_why`=1 (power fail), then moves to G3. At most one event pulse is high in any cycle.
- R5: S3 checks its inputs in a fixed priority order. Lost power-good comes first and goes to S3S5 with the strobe and reason 1. A high S3 indicator comes next and goes to S3S0. A low S4 indicator comes last and goes to S3S5 without the strobe. With none of these, the sequencer stays in S3.
- R6: S3S0 re-checks power-good. Without it, the sequencer goes to S3S5 with the strobe and reason 1. With it, the sequencer goes to S0 and, in the first S0 cycle, shows `radio_ctrl`=2 (on), an `evt_resume` pulse and `cpu_throttle` at its inactive level.
- R7: In S0, lost power-good goes to S0S3 with the strobe and reason 1. A low S3 indicator also goes to S0S3. S0S3 moves to S3, and in the first S3 cycle shows `radio_ctrl`=1 (suspend) and an `evt_suspend` pulse.
- R8: S0 moves to S0S0IX only when `idle_suspend_req` is 1 and the S0 indicator is low. A low S0 indicator without the request leaves the sequencer in S0. S0S0IX moves to S0IX and pulses `evt_suspend` in the first S0IX cycle.
- R9: S0IX moves to S0IXS0 only when both the S0 and S3 indicators are high, and S0IXS0 then moves to S0. Otherwise, lost power-good moves S0IX straight to S0.
- R10: S3S5 always moves to S5, never to G3. The first S5 cycle shows `radio_ctrl`=0 and an `evt_shutdown` pulse.
- R11: With the default two synchroniser stages, a change on a sleep indicator, power-good or rails-ready first affects `pstate` on the third rising edge after the change.
- R12: While in S0, `cpu_throttle` follows `throttle_req` one cycle later (request 1 gives the asserted level). Outside S0, `throttle_req` is ignored and the pin holds its value.
- R13: Every transition state other than G3S5 lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slp_s3_n | input | 1 | S3 sleep indicator, low = asserted (asynchronous) |
| slp_s4_n | input | 1 | S4 sleep indicator, low = asserted (asynchronous) |
| slp_s0_n | input | 1 | S0 idle sleep indicator, low = asserted (asynchronous) |
| core_pwr_ok | input | 1 | Combined core power-good (asynchronous) |
| rails_ready | input | 1 | Required power signals present for leaving G3 (asynchronous) |
| wake_req | input | 1 | Request to leave G3 (synchronous) |
| idle_suspend_req | input | 1 | Host has announced an idle suspend (synchronous) |
| throttle_req | input | 1 | Request to throttle the CPU while running (synchronous) |
| pstate | output | 4 | Current state code (see R2) |
| shutdown_strobe | output | 1 | One-cycle forced-shutdown strobe |
| shutdown_why | output | 2 | Reason of the last forced shutdown: 0 none, 1 power fail, 2 wait timeout |
| radio_ctrl | output | 2 | Radio control: 0 off, 1 suspend, 2 on |
| cpu_throttle | output | 1 | CPU throttle pin, polarity set by THROTTLE_ACTIVE_LOW |
| evt_startup | output | 1 | Startup event pulse |
| evt_resume | output | 1 | Resume event pulse |
| evt_suspend | output | 1 | Suspend event pulse |
| evt_shutdown | output | 1 | Shutdown event pulse |

## Verification
The bench parks the sequencer in S3, S0 and S0IX and sweeps every combination of the inputs that each of these states inspects, computing the expected next state from the stated priority. A wrong priority order would send lost power into a resume, or leave a suspend without the power-fail strobe. A missing idle-suspend gate would drop into S0IX on a bare low S0 indicator. The bench also times the rails wait to the exact cycle of its expiry, so an off-by-one counter shows up as an early or late return to G3. It further checks the synchroniser delay, the S3S5-to-S5 landing, which a shortcut to G3 would break, and that the throttle request has no effect outside S0.

// File: rtl/slpseq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the sleep-state sequencer.
// Assumes: state codes are visible at the top port and must stay fixed.
package slpseq_pkg;

    typedef enum logic [3:0] {
        ST_G3     = 4'd0,
        ST_G3S5   = 4'd1,
        ST_S5     = 4'd2,
        ST_S5S3   = 4'd3,
        ST_S3     = 4'd4,
        ST_S3S0   = 4'd5,
        ST_S0     = 4'd6,
        ST_S0S3   = 4'd7,
        ST_S0S0IX = 4'd8,
        ST_S0IX   = 4'd9,
        ST_S0IXS0 = 4'd10,
        ST_S3S5   = 4'd11,
        ST_S5G3   = 4'd12
    } pstate_e;

    typedef enum logic [1:0] {
        WHY_NONE    = 2'd0,
        WHY_PWRFAIL = 2'd1,
        WHY_WAITTMO = 2'd2
    } why_e;

    typedef enum logic [1:0] {
        RF_OFF     = 2'd0,
        RF_SUSPEND = 2'd1,
        RF_ON      = 2'd2
    } rf_e;

    // Bit positions of the synchronised input vector.
    localparam int IDX_S3    = 0;
    localparam int IDX_S4    = 1;
    localparam int IDX_S0    = 2;
    localparam int IDX_PG    = 3;
    localparam int IDX_RAILS = 4;
    localparam int NUM_ASYNC = 5;

endpackage

// File: rtl/slpseq_sync.sv
`timescale 1ns/1ps
// Module: multi-bit flop-chain synchroniser.
// Each bit is independent; assumes no bit needs coherence with another.
// Reset clears every stage to zero.
module slpseq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (g == 0) begin : g_first
                // Capture the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= d;
                end
            end else begin : g_next
                // Pass the value one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) r <= '0;
                    else        r <= g_stage[g-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/slpseq_wait_timer.sv
`timescale 1ns/1ps
// Module: bounded wait counter for the rails wait out of G3.
// Counts while run is high. expired is high in the last allowed cycle,
// so run lasts at most WAIT_CYCLES cycles. Assumes WAIT_CYCLES >= 1.
module slpseq_wait_timer #(
    parameter int WAIT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES + 1) : 1;

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(WAIT_CYCLES - 1));

    // Advance while waiting; clear when idle or at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || expired) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    // R3: the count never reaches the limit, so the wait is bounded.
    assert_wait_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < WAIT_CYCLES);

endmodule

// File: rtl/slpseq_fsm.sv
`timescale 1ns/1ps
// Module: sleep-state decision logic and registered side effects.
// Assumes all level inputs are already synchronous to clk.
// A transition state's actions show in the cycle after it.
// A forced-shutdown strobe shows together with the state it forced.
module slpseq_fsm
    import slpseq_pkg::*;
#(
    parameter bit THROTTLE_ACTIVE_LOW = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    s3_n,
    input  logic    s4_n,
    input  logic    s0_n,
    input  logic    pg,
    input  logic    rails,
    input  logic    wake_req,
    input  logic    idle_req,
    input  logic    throttle_req,
    input  logic    wait_expired,
    output logic    wait_run,
    output pstate_e st,
    output logic    shut_strobe,
    output why_e    shut_why,
    output rf_e     rf_ctrl,
    output logic    throttle_pin,
    output logic    evt_startup,
    output logic    evt_resume,
    output logic    evt_suspend,
    output logic    evt_shutdown
);

    localparam logic THR_ON  = THROTTLE_ACTIVE_LOW ? 1'b0 : 1'b1;
    localparam logic THR_OFF = ~THR_ON;

    pstate_e nxt;
    logic    fail_pwr;
    logic    fail_wait;
    logic    is_transient;

    assign wait_run     = (st == ST_G3S5);
    assign is_transient = (st == ST_S5S3) || (st == ST_S3S0) || (st == ST_S0S3) ||
                          (st == ST_S0S0IX) || (st == ST_S0IXS0) ||
                          (st == ST_S3S5) || (st == ST_S5G3);

    // Choose the next state and flag any forced shutdown.
    always_comb begin
        nxt       = st;
        fail_pwr  = 1'b0;
        fail_wait = 1'b0;
        case (st)
            ST_G3:     if (wake_req) nxt = ST_G3S5;
            ST_G3S5: begin
                if (rails) nxt = ST_S5;
                else if (wait_expired) begin
                    nxt       = ST_G3;
                    fail_wait = 1'b1;
                end
            end
            ST_S5:     if (s4_n) nxt = ST_S5S3;
            ST_S5S3: begin
                if (!pg) begin
                    nxt      = ST_S5G3;
                    fail_pwr = 1'b1;
                end else nxt = ST_S3;
            end
            ST_S3: begin
                if (!pg) begin
                    nxt      = ST_S3S5;
                    fail_pwr = 1'b1;
                end else if (s3_n)  nxt = ST_S3S0;
                else if (!s4_n)     nxt = ST_S3S5;
            end
            ST_S3S0: begin
                if (!pg) begin
                    nxt      = ST_S3S5;
                    fail_pwr = 1'b1;
                end else nxt = ST_S0;
            end
            ST_S0: begin
                if (!pg) begin
                    nxt      = ST_S0S3;
                    fail_pwr = 1'b1;
                end else if (!s3_n)           nxt = ST_S0S3;
                else if (idle_req && !s0_n)   nxt = ST_S0S0IX;
            end
            ST_S0S0IX: nxt = ST_S0IX;
            ST_S0IX: begin
                if (s0_n && s3_n) nxt = ST_S0IXS0;
                else if (!pg)     nxt = ST_S0;
            end
            ST_S0IXS0: nxt = ST_S0;
            ST_S0S3:   nxt = ST_S3;
            ST_S3S5:   nxt = ST_S5;
            ST_S5G3:   nxt = ST_G3;
            default:   nxt = ST_G3;
        endcase
    end

    // Register the state and the shutdown strobe with its reason.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_G3;
            shut_strobe <= 1'b0;
            shut_why    <= WHY_NONE;
        end else begin
            st          <= nxt;
            shut_strobe <= fail_pwr || fail_wait;
            if (fail_pwr)       shut_why <= WHY_PWRFAIL;
            else if (fail_wait) shut_why <= WHY_WAITTMO;
        end
    end

    // Emit one-cycle event pulses when a transition state completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_startup  <= 1'b0;
            evt_resume   <= 1'b0;
            evt_suspend  <= 1'b0;
            evt_shutdown <= 1'b0;
        end else begin
            evt_startup  <= (st == ST_S5S3) && pg;
            evt_resume   <= (st == ST_S3S0) && pg;
            evt_suspend  <= (st == ST_S0S3) || (st == ST_S0S0IX);
            evt_shutdown <= (st == ST_S3S5);
        end
    end

    // Drive radio control and the throttle pin from the completed transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_ctrl      <= RF_OFF;
            throttle_pin <= THR_ON;
        end else begin
            if ((st == ST_S3S0) && pg) begin
                rf_ctrl      <= RF_ON;
                throttle_pin <= THR_OFF;
            end else if (st == ST_S0S3) begin
                rf_ctrl <= RF_SUSPEND;
            end else if ((st == ST_S3S5) || (st == ST_S5G3)) begin
                rf_ctrl <= RF_OFF;
            end
            if (st == ST_S0) throttle_pin <= throttle_req ? THR_ON : THR_OFF;
        end
    end

    // R5: power loss in S3 wins and raises a power-fail strobe.
    assert_s3_pwrfail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S3 && !pg) |=> (st == ST_S3S5 && shut_strobe && shut_why == WHY_PWRFAIL));

    // R13: transition states hold for a single cycle.
    assert_transient_once_R13: assert property (@(posedge clk) disable iff (!rst_n)
        is_transient |=> (st != $past(st)));

    // R10: leaving S3 downwards always lands in S5.
    assert_s3s5_to_s5_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S3S5) |=> (st == ST_S5));

    // R8: no idle entry without the host announcement.
    assert_idle_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S0 && !idle_req) |=> (st != ST_S0S0IX));

    // R9: idle exit needs both indicators released.
    assert_idle_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_S0IX && !(s0_n && s3_n)) |=> (st != ST_S0IXS0));

    // R4: event pulses never overlap.
    assert_evt_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_startup, evt_resume, evt_suspend, evt_shutdown}));

    // R3: an expired wait returns to G3 with the timeout reason.
    assert_wait_timeout_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_G3S5 && wait_expired && !rails) |=>
        (st == ST_G3 && shut_strobe && shut_why == WHY_WAITTMO));

endmodule

// File: rtl/slpseq_top.sv
`timescale 1ns/1ps
// Module: platform sleep-state sequencer top.
// Synchronises the asynchronous level inputs, bounds the rails wait and
// runs the state machine. Assumes wake, idle and throttle requests are
// synchronous to clk.
module slpseq_top
    import slpseq_pkg::*;
#(
    parameter int WAIT_CYCLES         = 1000,
    parameter int SYNC_STAGES         = 2,
    parameter bit THROTTLE_ACTIVE_LOW = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_s3_n,
    input  logic       slp_s4_n,
    input  logic       slp_s0_n,
    input  logic       core_pwr_ok,
    input  logic       rails_ready,
    input  logic       wake_req,
    input  logic       idle_suspend_req,
    input  logic       throttle_req,
    output logic [3:0] pstate,
    output logic       shutdown_strobe,
    output logic [1:0] shutdown_why,
    output logic [1:0] radio_ctrl,
    output logic       cpu_throttle,
    output logic       evt_startup,
    output logic       evt_resume,
    output logic       evt_suspend,
    output logic       evt_shutdown
);

    logic [NUM_ASYNC-1:0] raw_in;
    logic [NUM_ASYNC-1:0] syn_in;
    logic                 wait_run;
    logic                 wait_expired;
    pstate_e              st;
    why_e                 why;
    rf_e                  rf;

    always_comb begin
        raw_in            = '0;
        raw_in[IDX_S3]    = slp_s3_n;
        raw_in[IDX_S4]    = slp_s4_n;
        raw_in[IDX_S0]    = slp_s0_n;
        raw_in[IDX_PG]    = core_pwr_ok;
        raw_in[IDX_RAILS] = rails_ready;
    end

    slpseq_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    slpseq_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_expired)
    );

    slpseq_fsm #(.THROTTLE_ACTIVE_LOW(THROTTLE_ACTIVE_LOW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .s3_n         (syn_in[IDX_S3]),
        .s4_n         (syn_in[IDX_S4]),
        .s0_n         (syn_in[IDX_S0]),
        .pg           (syn_in[IDX_PG]),
        .rails        (syn_in[IDX_RAILS]),
        .wake_req     (wake_req),
        .idle_req     (idle_suspend_req),
        .throttle_req (throttle_req),
        .wait_expired (wait_expired),
        .wait_run     (wait_run),
        .st           (st),
        .shut_strobe  (shutdown_strobe),
        .shut_why     (why),
        .rf_ctrl      (rf),
        .throttle_pin (cpu_throttle),
        .evt_startup  (evt_startup),
        .evt_resume   (evt_resume),
        .evt_suspend  (evt_suspend),
        .evt_shutdown (evt_shutdown)
    );

    assign pstate       = st;
    assign shutdown_why = why;
    assign radio_ctrl   = rf;

endmodule

// File: tb/slpseq_top_test.sv
`timescale 1ns/1ps
// Bench: sweeps the inputs each resting state inspects and checks the
// state codes, strobes and side effects against values computed here.
module slpseq_top_test;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s3 = 1'b0, s4 = 1'b0, s0 = 1'b0, pg = 1'b1, rails = 1'b0;
    logic wake = 1'b0, idle = 1'b0, thr = 1'b0;
    logic [3:0] pstate;
    logic       strobe, cpu_thr, e_start, e_res, e_sus, e_shut;
    logic [1:0] why, radio;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    slpseq_top #(.WAIT_CYCLES(W), .SYNC_STAGES(2), .THROTTLE_ACTIVE_LOW(1'b1)) uut (
        .clk(clk), .rst_n(rst_n),
        .slp_s3_n(s3), .slp_s4_n(s4), .slp_s0_n(s0),
        .core_pwr_ok(pg), .rails_ready(rails), .wake_req(wake),
        .idle_suspend_req(idle), .throttle_req(thr),
        .pstate(pstate), .shutdown_strobe(strobe), .shutdown_why(why),
        .radio_ctrl(radio), .cpu_throttle(cpu_thr),
        .evt_startup(e_start), .evt_resume(e_res),
        .evt_suspend(e_sus), .evt_shutdown(e_shut)
    );

    task automatic t(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int want);
        nchk++;
        if (act != want) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, want);
        end
    endtask

    task automatic boot();
        rst_n = 1'b0;
        s3 = 1'b0; s4 = 1'b0; s0 = 1'b0; pg = 1'b1; rails = 1'b0;
        wake = 1'b0; idle = 1'b0; thr = 1'b0;
        t(3);
        rst_n = 1'b1;
        t(3);
    endtask

    task automatic to_s5();
        boot();
        rails = 1'b1;
        t(3);
        wake = 1'b1;
        t(1);
        wake = 1'b0;
        t(1);
    endtask

    task automatic to_s3();
        to_s5();
        s4 = 1'b1;
        t(4);
    endtask

    task automatic to_s0();
        to_s3();
        s3 = 1'b1; s0 = 1'b1;
        t(4);
    endtask

    task automatic to_s0ix();
        to_s0();
        idle = 1'b1; s0 = 1'b0;
        t(4);
    endtask

    initial begin
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: values under reset
        rst_n = 1'b0;
        t(3);
        chk("R1 state", pstate, 0);
        chk("R1 radio", radio, 0);
        chk("R1 strobe", strobe, 0);
        chk("R1 why", why, 0);
        chk("R1 events", {e_start, e_res, e_sus, e_shut}, 0);
        chk("R1 throttle", cpu_thr, 0);
        boot();
        chk("R1 state after release", pstate, 0);

        // R2: wake and rails-ready path to S5
        rails = 1'b1;
        t(3);
        wake = 1'b1;
        t(1);
        wake = 1'b0;
        chk("R2 G3S5", pstate, 1);
        t(1);
        chk("R2 S5", pstate, 2);

        // R3: rails wait expires after exactly W cycles
        boot();
        wake = 1'b1;
        t(1);
        wake = 1'b0;
        chk("R3 enter wait", pstate, 1);
        t(W - 1);
        chk("R3 still waiting", pstate, 1);
        chk("R3 no early strobe", strobe, 0);
        t(1);
        chk("R3 back to G3", pstate, 0);
        chk("R3 strobe", strobe, 1);
        chk("R3 reason", why, 2);
        t(1);
        chk("R3 strobe one cycle", strobe, 0);

        // R4: S5 up to S3 with startup pulse
        to_s5();
        s4 = 1'b1;
        t(3);
        chk("R4 S5S3", pstate, 3);
        t(1);
        chk("R4 S3", pstate, 4);
        chk("R4 startup", e_start, 1);
        chk("R4 startup only", {e_res, e_sus, e_shut}, 0);
        // R4: power missing in S5S3
        to_s5();
        s4 = 1'b1; pg = 1'b0;
        t(3);
        chk("R4 S5S3 nopg", pstate, 3);
        t(1);
        chk("R4 S5G3", pstate, 12);
        chk("R4 pf strobe", strobe, 1);
        chk("R4 pf reason", why, 1);
        t(1);
        chk("R4 G3", pstate, 0);
        chk("R4 no startup", e_start, 0);

        // R5 / R11: priority sweep in S3
        for (int c = 0; c < 8; c++) begin
            logic vp, v3, v4;
            int want, wstb;
            vp = c[2]; v3 = c[1]; v4 = c[0];
            to_s3();
            pg = vp; s3 = v3; s4 = v4;
            t(2);
            chk("R11 S3 holds two edges", pstate, 4);
            t(1);
            if (!vp)      begin want = 11; wstb = 1; end
            else if (v3)  begin want = 5;  wstb = 0; end
            else if (!v4) begin want = 11; wstb = 0; end
            else          begin want = 4;  wstb = 0; end
            chk("R5 S3 next", pstate, want);
            chk("R5 S3 strobe", strobe, wstb);
            if (wstb == 1) chk("R5 S3 reason", why, 1);
        end

        // R6: resume side effects
        to_s3();
        s3 = 1'b1;
        t(3);
        chk("R6 S3S0", pstate, 5);
        chk("R6 throttle before", cpu_thr, 0);
        t(1);
        chk("R6 S0", pstate, 6);
        chk("R6 radio on", radio, 2);
        chk("R6 resume", e_res, 1);
        chk("R6 throttle off", cpu_thr, 1);
        t(1);
        chk("R6 resume one cycle", e_res, 0);
        // R6: power lost during S3S0
        to_s3();
        s3 = 1'b1;
        t(1);
        pg = 1'b0;
        t(2);
        chk("R6 S3S0 again", pstate, 5);
        t(1);
        chk("R6 fail to S3S5", pstate, 11);
        chk("R6 fail strobe", strobe, 1);
        chk("R6 fail reason", why, 1);
        chk("R6 radio stays off", radio, 0);
        t(1);
        chk("R13 S3S5 one cycle", pstate, 2);

        // R7 / R8: sweep in S0
        for (int c = 0; c < 16; c++) begin
            logic vp, v3, v0, vi;
            int want;
            vp = c[3]; v3 = c[2]; v0 = c[1]; vi = c[0];
            to_s0();
            pg = vp; s3 = v3; s0 = v0; idle = vi;
            t(2);
            chk("R8 S0 holds two edges", pstate, 6);
            t(1);
            if (!vp || !v3)     want = 7;
            else if (vi && !v0) want = 8;
            else                want = 6;
            chk("R7 R8 S0 next", pstate, want);
            chk("R7 S0 strobe", strobe, (!vp) ? 1 : 0);
            t(1);
            if (want == 7) begin
                chk("R7 S3 after", pstate, 4);
                chk("R7 radio suspend", radio, 1);
                chk("R7 suspend evt", e_sus, 1);
            end else if (want == 8) begin
                chk("R8 S0IX after", pstate, 9);
                chk("R8 suspend evt", e_sus, 1);
            end else begin
                chk("R8 stays S0", pstate, 6);
                chk("R8 no suspend evt", e_sus, 0);
            end
        end

        // R9: sweep in S0IX
        for (int c = 0; c < 8; c++) begin
            logic vp, v3, v0;
            int want;
            vp = c[2]; v3 = c[1]; v0 = c[0];
            to_s0ix();
            chk("R8 in S0IX", pstate, 9);
            pg = vp; s3 = v3; s0 = v0;
            t(3);
            if (v0 && v3) want = 10;
            else if (!vp) want = 6;
            else          want = 9;
            chk("R9 S0IX next", pstate, want);
            if (want == 10) begin
                t(1);
                chk("R9 back to S0", pstate, 6);
            end
        end

        // R10: full descent keeps S5
        to_s0();
        s3 = 1'b0;
        t(4);
        chk("R10 in S3", pstate, 4);
        s4 = 1'b0;
        t(3);
        chk("R10 S3S5", pstate, 11);
        t(1);
        chk("R10 lands S5", pstate, 2);
        chk("R10 radio off", radio, 0);
        chk("R10 shutdown evt", e_shut, 1);
        t(1);
        chk("R10 still S5", pstate, 2);

        // R12: throttle follows request only in S0
        to_s0();
        thr = 1'b1;
        t(1);
        chk("R12 throttle on", cpu_thr, 0);
        thr = 1'b0;
        t(1);
        chk("R12 throttle off", cpu_thr, 1);
        s3 = 1'b0;
        t(4);
        chk("R12 in S3", pstate, 4);
        thr = 1'b1;
        t(2);
        chk("R12 ignored in S3", cpu_thr, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule